// File: doc/BRIEF.md
# Dual-Modulus Divide-by-2/3 Prescaler

This block divides a fast input clock by two or by three, as chosen by a one-bit ratio-select input. It is meant to be the first stage of a pulse-swallowing divider chain. The downstream counters drive the ratio select to choose how many three-long cycles fall inside each longer division period. The divided output is a one-input-period pulse at the start of every division cycle.

Two state flops do the division. A lead flop produces the output pulse. A swallow flop adds one extra input period to a cycle, but only in divide-by-3. The ratio select is captured once per division cycle, on the clock edge that starts a new cycle. A ratio change therefore always takes effect on a whole cycle. The swallow flop has a clock enable that follows the captured ratio. In divide-by-2 it never updates and rests at zero, so it does not toggle at all. A debug output shows that enable in every input cycle.

Top module: `dual_mod_prescaler`

## Requirements
- R1: When the ratio captured for a division cycle is 1 (divide-by-3), the output repeats with a period of exactly three input clocks.
- R2: When the ratio captured for a division cycle is 0 (divide-by-2), the output repeats with a period of exactly two input clocks.
- R3: The output `div_out` is high for exactly one input period per division cycle. That period is the first of the cycle.
- R4: `ratio_sel` is captured only on the clock edge that raises `div_out`. Values it holds at any other edge have no effect. No division cycle is ever one or four input clocks long.
- R5: `swallow_en` is 1 throughout a divide-by-3 cycle and 0 throughout a divide-by-2 cycle. While it is 0, the swallow flop does not change state and holds 0.
- R6: Driving `rst_n` low clears both flops and the captured ratio at once: `div_out` = 0 and `swallow_en` = 0. Release is synchronised over `SYNC_STAGES` clocks. The first division cycle afterwards uses the ratio present at its starting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| ratio_sel | input | 1 | 1 selects divide-by-3, 0 selects divide-by-2 |
| div_out | output | 1 | Divided clock, one input period high at each cycle start |
| swallow_en | output | 1 | Debug: clock enable of the swallow flop in this input cycle |

## Verification
A fixed ratio sequence is walked cycle by cycle. It contains runs of divide-by-3, runs of divide-by-2 and single-cycle alternations. The sequence tells whether the period follows the ratio captured at the cycle boundary or lags or leads it by one cycle. A pulse on `ratio_sel` in the middle of a three-long cycle, undone before the next boundary, must leave the periods unchanged. This separates boundary capture from continuous sampling. A reset in the middle of a cycle with divide-by-2 selected checks the immediate clear and that the first cycle after release follows the new ratio.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
  typedef enum logic {
    RATIO_DIV2 = 1'b0,
    RATIO_DIV3 = 1'b1
  } ratio_e;
endpackage

// File: rtl/ps_reset_sync.sv
module ps_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ps_ratio_latch.sv
module ps_ratio_latch
  import prescaler_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   capture,
  input  logic   ratio_in,
  output ratio_e ratio_q
);
  ratio_e ratio_d;

  always_comb begin
    ratio_d = ratio_q;
    if (capture) ratio_d = ratio_e'(ratio_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ratio_q <= RATIO_DIV2;
    else        ratio_q <= ratio_d;
  end

  // Ratio changes only on the boundary edge.
  assert_ratio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(ratio_q));
endmodule

// File: rtl/ps_lead_stage.sv
module ps_lead_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic swallow_q,
  output logic lead_q,
  output logic cycle_start
);
  logic lead_d;

  always_comb begin
    // New cycle starts only after the lead pulse and any swallowed period.
    lead_d      = ~lead_q & ~swallow_q;
    cycle_start = lead_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lead_q <= 1'b0;
    else        lead_q <= lead_d;
  end

  assert_single_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |=> !lead_q);
endmodule

// File: rtl/ps_swallow_stage.sv
module ps_swallow_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic lead_q,
  output logic swallow_q
);
  logic swallow_d;

  always_comb begin
    swallow_d = swallow_q;
    if (enable) swallow_d = lead_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swallow_q <= 1'b0;
    else        swallow_q <= swallow_d;
  end

  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(swallow_q));
  assert_quiet_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !swallow_q);
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import prescaler_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ratio_sel,
  output logic div_out,
  output logic swallow_en
);
  logic   rst_sync_n;
  logic   lead_q;
  logic   swallow_q;
  logic   cycle_start;
  ratio_e ratio_q;
  logic   stage_en;

  ps_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ps_ratio_latch u_ratio (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .capture  (cycle_start),
    .ratio_in (ratio_sel),
    .ratio_q  (ratio_q)
  );

  ps_lead_stage u_lead (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .swallow_q   (swallow_q),
    .lead_q      (lead_q),
    .cycle_start (cycle_start)
  );

  always_comb begin
    stage_en = (ratio_q == RATIO_DIV3);
  end

  ps_swallow_stage u_swallow (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (stage_en),
    .lead_q    (lead_q),
    .swallow_q (swallow_q)
  );

  assign div_out    = lead_q;
  assign swallow_en = stage_en;

  assert_div2_period_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_out && !swallow_en) |=> !div_out ##1 div_out);
  assert_div3_period_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_out && swallow_en) |=> !div_out ##1 !div_out ##1 div_out);
  assert_reset_clear_R6: assert property (@(posedge clk)
    !rst_n |-> (!div_out && !swallow_en));
endmodule

// File: tb/dual_mod_prescaler_tb.sv
`timescale 1ns/1ps
module dual_mod_prescaler_tb;
  localparam int SYNC = 2;

  typedef struct packed {
    logic     mc;
    int       exp_len;
  } vec_t;

  localparam vec_t TAB [12] = '{
    '{1'b1, 3}, '{1'b0, 3}, '{1'b0, 2}, '{1'b1, 2},
    '{1'b1, 3}, '{1'b0, 3}, '{1'b1, 2}, '{1'b0, 3},
    '{1'b1, 2}, '{1'b1, 3}, '{1'b0, 3}, '{1'b0, 2}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ratio_sel;
  logic div_out;
  logic swallow_en;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  dual_mod_prescaler #(.SYNC_STAGES(SYNC)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_sel  (ratio_sel),
    .div_out    (div_out),
    .swallow_en (swallow_en)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_boundary(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_out && n < 10);
  endtask

  // Called at a boundary sample. Applies mc for the next capture and
  // checks the current cycle length and enable.
  task automatic run_cycle(input logic mc, input int exp_len, input bit glitch);
    string req;
    int    len;
    req = (exp_len == 3) ? "R1" : "R2";
    ratio_sel = mc;
    check("R5", "swallow_en at cycle start", swallow_en, exp_len == 3);
    len = 0;
    forever begin
      @(negedge clk);
      len++;
      if (glitch && len == 1) ratio_sel = ~mc;  // R4: mid-cycle change
      if (glitch && len == 2) ratio_sel = mc;
      if (div_out || len >= 6) break;
      check("R5", "swallow_en inside cycle", swallow_en, exp_len == 3);
    end
    check(req, "cycle length", len, exp_len);
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    ratio_sel = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", "div_out in reset", div_out, 0);
    check("R6", "swallow_en in reset", swallow_en, 0);
    rst_n = 1'b1;
    wait_boundary(n);
    check("R6", "first pulse latency", n, SYNC + 1);

    // R1 R2 R3 R5: table walk
    foreach (TAB[i]) run_cycle(TAB[i].mc, TAB[i].exp_len, 1'b0);

    // R4: mid-cycle ratio pulse inside a three-long cycle is ignored
    run_cycle(1'b1, 2, 1'b0);
    run_cycle(1'b1, 3, 1'b1);
    run_cycle(1'b0, 3, 1'b0);
    run_cycle(1'b0, 2, 1'b0);

    // R6: reset in the middle of a cycle, divide-by-2 afterwards
    run_cycle(1'b1, 2, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    ratio_sel = 1'b0;
    #1;
    check("R6", "div_out cleared at once", div_out, 0);
    check("R6", "swallow_en cleared at once", swallow_en, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_boundary(n);
    check("R6", "pulse latency after reset", n, SYNC + 1);
    run_cycle(1'b0, 2, 1'b0);
    run_cycle(1'b1, 2, 1'b0);
    run_cycle(1'b1, 3, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule